// File: doc/BRIEF.md
# Video Error Flag Status and Errored-Field Counter

This block gathers fifteen per-field error indications from a video error-detection datapath and presents them to a host through a small register port. The indications form a grid of three picture regions (ancillary data, active picture, full field) by five error kinds (EDH, EDA, IDH, IDA, UES). The flag index is `region*5 + kind`. Regions are numbered ancillary=0, active picture=1, full field=2. Kinds are numbered EDH=0, EDA=1, IDH=2, IDA=3, UES=4.

Each flag can be masked individually. A global hold mode keeps flags set until the host reads them. Sensitivity bits select which flags raise the level interrupt and advance a saturating errored-field counter. Four EDH/EDA/IDH/IDA sensitivity bits exist per region, and one shared bit covers UES in every region. The counter can be held at zero by command, or cleared automatically after each host read of its value. A strap pair sampled during reset presets the TRS-select control bit for operation without a host.

The host port uses single-cycle write and read strobes. Read data is combinational from the current state. The register map is:
- address 0: flags, read-only.
- address 1: masks in bits 14:0, hold mode in bit 15.
- address 2: sensitivity. Bit `region*4+kind` covers kinds 0..3, and bit 12 is the shared UES bit.
- address 3: control. Bit 0 is counter clear, bit 1 is auto-clear, bit 2 is TRS select.
- address 4: counter, read-only.

Top module: `efs_top`

## Requirements
- R1: After reset, the mask register and the control bits are 0, the sensitivity register is all ones (0x1FFF), and the flags, the counter and `irq_o` are 0.
- R2: With hold mode off, the flag register takes the masked error vector at each `field_end_i` strobe and changes at no other time. A host read of address 0 does not clear it.
- R3: A flag whose mask bit is 1 is never set, and it adds neither to the interrupt nor to the counter.
- R4: With hold mode on (address 1 bit 15), a set flag stays set across later fields until the host reads address 0. That read clears all held flags at the next clock edge.
- R5: A sensitivity bit of 0 removes its flag from the interrupt and the counter, but the flag still shows in the flag register. Bit 12 governs the UES flag of all three regions.
- R6: `irq_o` is 1 exactly while some stored flag is set, unmasked and sensitive under the current mask and sensitivity settings.
- R7: While control bit 0 is 1, the counter reads 0 and does not count.
- R8: With control bit 1 set, a host read of address 4 returns the count, and the counter then restarts from 0. With that bit clear, reads leave the count unchanged.
- R9: The counter adds at most one per `field_end_i` strobe with a sensitive, unmasked error, and it saturates at 2^CNT_W-1.
- R10: Control bit 2 resets to 1 when `strap_i` is 2'b01 during reset, and to 0 otherwise. It is also driven on `trs_sel_o`.
- R11: When a flag-clearing read or a counter auto-clear read happens in the same cycle as a field strobe, the read returns the old value, and the new field's errors are kept after the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strap_i | input | 2 | Strap pins sampled during reset |
| field_end_i | input | 1 | End-of-field strobe qualifying err_i |
| err_i | input | 15 | Per-field raw error indications |
| wr_en_i | input | 1 | Host write strobe |
| rd_en_i | input | 1 | Host read strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Host write data |
| rdata_o | output | 16 | Host read data |
| irq_o | output | 1 | Level interrupt |
| trs_sel_o | output | 1 | TRS-select control bit |

## Verification
The bench builds the block with CNT_W=4, so the counter reaches its saturation value of 15 after a short run of errored fields. With this width the bench can check the hold at the top and the auto-clear from full scale without long runs. The remaining parameters keep their defaults, so the full 15-flag grid is exercised, including the shared UES sensitivity bit across all three regions. Reset is applied twice with different strap values to cover both presets of the TRS-select bit.

// File: rtl/efs_pkg.sv
package efs_pkg;
  localparam int NREG   = 3;
  localparam int NKIND  = 5;
  localparam int NFLAG  = NREG * NKIND;
  localparam int NSKIND = NKIND - 1;           // kinds with per-region sensitivity
  localparam int NSENS  = NREG * NSKIND + 1;   // plus one shared UES bit
  localparam int AW     = 3;
  localparam int DW     = 16;
  localparam int STICKY_BIT = DW - 1;

  typedef enum logic [AW-1:0] {
    A_FLAGS = 3'd0,
    A_MASK  = 3'd1,
    A_SENS  = 3'd2,
    A_CTRL  = 3'd3,
    A_CNT   = 3'd4
  } reg_addr_e;

  function automatic logic [NFLAG-1:0] sens_expand(input logic [NSENS-1:0] s);
    logic [NFLAG-1:0] x;
    for (int r = 0; r < NREG; r++) begin
      for (int k = 0; k < NKIND; k++) begin
        x[r*NKIND+k] = (k == NKIND-1) ? s[NSENS-1] : s[r*NSKIND+k];
      end
    end
    return x;
  endfunction
endpackage

// File: rtl/efs_regs.sv
module efs_regs
  import efs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       strap_i,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [NFLAG-1:0] mask_o,
  output logic             sticky_o,
  output logic [NSENS-1:0] sens_o,
  output logic             cnt_clr_o,
  output logic             auto_clr_o,
  output logic             trs_sel_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o     <= '0;
      sticky_o   <= 1'b0;
      sens_o     <= '1;
      cnt_clr_o  <= 1'b0;
      auto_clr_o <= 1'b0;
      trs_sel_o  <= (strap_i == 2'b01);
    end else if (wr_en_i) begin
      unique case (addr_i)
        A_MASK: begin
          mask_o   <= wdata_i[NFLAG-1:0];
          sticky_o <= wdata_i[STICKY_BIT];
        end
        A_SENS: sens_o <= wdata_i[NSENS-1:0];
        A_CTRL: begin
          cnt_clr_o  <= wdata_i[0];
          auto_clr_o <= wdata_i[1];
          trs_sel_o  <= wdata_i[2];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/efs_flags.sv
module efs_flags
  import efs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             field_end_i,
  input  logic [NFLAG-1:0] err_i,
  input  logic [NFLAG-1:0] mask_i,
  input  logic             sticky_i,
  input  logic [NFLAG-1:0] sens_x_i,
  input  logic             rd_clr_i,
  output logic [NFLAG-1:0] flags_o,
  output logic             irq_o
);
  logic [NFLAG-1:0] masked, flags_d;

  assign masked = err_i & ~mask_i;

  always_comb begin
    if (sticky_i)
      // new event beats a same-cycle clearing read
      flags_d = (rd_clr_i ? '0 : flags_o) | (field_end_i ? masked : '0);
    else
      flags_d = field_end_i ? masked : flags_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_o <= '0;
    else         flags_o <= flags_d;
  end

  assign irq_o = |(flags_o & ~mask_i & sens_x_i);
endmodule

// File: rtl/efs_counter.sv
module efs_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  logic             hold_clr_i,
  input  logic             rd_clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CMAX = '1;
  logic [CNT_W-1:0] base, cnt_d;

  always_comb begin
    base = rd_clr_i ? '0 : cnt_o;
    if (hold_clr_i)                 cnt_d = '0;
    else if (hit_i && base != CMAX) cnt_d = base + 1'b1;
    else                            cnt_d = base;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else         cnt_o <= cnt_d;
  end
endmodule

// File: rtl/efs_top.sv
module efs_top
  import efs_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       strap_i,
  input  logic             field_end_i,
  input  logic [NFLAG-1:0] err_i,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic             irq_o,
  output logic             trs_sel_o
);
  logic [NFLAG-1:0] mask, sens_x, flags_q;
  logic [NSENS-1:0] sens;
  logic             sticky, cnt_clr, auto_clr, rd_flags, rd_cnt, hit;
  logic [CNT_W-1:0] cnt_q;

  assign sens_x   = sens_expand(sens);
  assign rd_flags = rd_en_i && (addr_i == A_FLAGS);
  assign rd_cnt   = rd_en_i && (addr_i == A_CNT) && auto_clr;
  assign hit      = field_end_i && |(err_i & ~mask & sens_x);

  efs_regs u_regs (
    .clk_i, .rst_ni, .strap_i, .wr_en_i, .addr_i, .wdata_i,
    .mask_o(mask), .sticky_o(sticky), .sens_o(sens),
    .cnt_clr_o(cnt_clr), .auto_clr_o(auto_clr), .trs_sel_o(trs_sel_o)
  );

  efs_flags u_flags (
    .clk_i, .rst_ni, .field_end_i, .err_i,
    .mask_i(mask), .sticky_i(sticky), .sens_x_i(sens_x),
    .rd_clr_i(rd_flags), .flags_o(flags_q), .irq_o(irq_o)
  );

  efs_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .hit_i(hit), .hold_clr_i(cnt_clr),
    .rd_clr_i(rd_cnt), .cnt_o(cnt_q)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_FLAGS: rdata_o[NFLAG-1:0] = flags_q;
      A_MASK:  begin
        rdata_o[NFLAG-1:0]  = mask;
        rdata_o[STICKY_BIT] = sticky;
      end
      A_SENS:  rdata_o[NSENS-1:0] = sens;
      A_CTRL:  rdata_o[2:0] = {trs_sel_o, auto_clr, cnt_clr};
      A_CNT:   rdata_o[CNT_W-1:0] = cnt_q;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/efs_checker.sv
module efs_checker
  import efs_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             field_end_i,
  input logic [NFLAG-1:0] flags_q,
  input logic             sticky,
  input logic             rd_flags,
  input logic             rd_cnt,
  input logic             cnt_clr,
  input logic [CNT_W-1:0] cnt_q,
  input logic             irq_o
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  a_r2_flags_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!field_end_i && !sticky) |=> $stable(flags_q));

  a_r4_sticky_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sticky && !rd_flags) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

  a_r6_irq_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_q == '0) |-> !irq_o);

  a_r7_clr_holds_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_clr |=> (cnt_q == '0));

  a_r8_auto_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_cnt && !field_end_i) |=> (cnt_q == '0));

  a_r9_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CMAX && !cnt_clr && !rd_cnt) |=> (cnt_q == CMAX));
endmodule

bind efs_top efs_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .field_end_i(field_end_i),
  .flags_q(flags_q), .sticky(sticky), .rd_flags(rd_flags),
  .rd_cnt(rd_cnt), .cnt_clr(cnt_clr), .cnt_q(cnt_q), .irq_o(irq_o)
);

// File: tb/efs_top_bench.sv
`timescale 1ns/100ps
module efs_top_bench;
  localparam int CNT_W = 4;

  typedef struct {
    int          kind;   // 0 rdata, 1 irq, 2 trs pin
    logic [15:0] exp;
    string       tag;
  } item_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  strap_i = 2'b00;
  logic        field_end_i = 1'b0;
  logic [14:0] err_i = '0;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        irq_o, trs_sel_o;

  int total = 0;
  int bad = 0;
  bit done = 0;
  item_t q[$];
  event mon_ev;

  always #2.5 clk_i = ~clk_i;

  efs_top #(.CNT_W(CNT_W)) u_efs_top (
    .clk_i, .rst_ni, .strap_i, .field_end_i, .err_i, .wr_en_i, .rd_en_i,
    .addr_i, .wdata_i, .rdata_o, .irq_o, .trs_sel_o
  );

  // monitor
  initial forever begin
    @(mon_ev);
    while (q.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = q.pop_front();
      act = (it.kind == 0) ? rdata_o : (it.kind == 1) ? {15'd0, irq_o} : {15'd0, trs_sel_o};
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic push(int kind, logic [15:0] exp, string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    q.push_back(it);
    ->mon_ev;
  endtask

  task automatic idle();
    @(negedge clk_i);
    field_end_i = 0; err_i = '0; wr_en_i = 0; rd_en_i = 0;
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk_i);
    wr_en_i = 1; rd_en_i = 0; field_end_i = 0; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 0;
  endtask

  // read with an optional simultaneous field strobe
  task automatic rd(logic [2:0] a, logic [15:0] exp, string tag,
                    bit fe = 0, logic [14:0] e = '0);
    @(negedge clk_i);
    rd_en_i = 1; wr_en_i = 0; addr_i = a; field_end_i = fe; err_i = e;
    #1 push(0, exp, tag);
    @(negedge clk_i);
    rd_en_i = 0; field_end_i = 0; err_i = '0;
  endtask

  task automatic field(logic [14:0] e);
    @(negedge clk_i);
    field_end_i = 1; err_i = e; rd_en_i = 0; wr_en_i = 0;
    @(negedge clk_i);
    field_end_i = 0; err_i = '0;
  endtask

  task automatic chk_irq(logic exp, string tag);
    @(negedge clk_i);
    #1 push(1, {15'd0, exp}, tag);
  endtask

  task automatic do_reset(logic [1:0] s);
    @(negedge clk_i);
    strap_i = s; rst_ni = 0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset(2'b00);
    // R1 defaults, R10 strap 00
    rd(3'd1, 16'h0000, "R1 mask default");
    rd(3'd2, 16'h1FFF, "R1 sens default");
    rd(3'd3, 16'h0000, "R10 ctrl with strap 00");
    rd(3'd0, 16'h0000, "R1 flags default");
    rd(3'd4, 16'h0000, "R1 counter default");
    chk_irq(1'b0, "R1 irq default");

    do_reset(2'b01);
    rd(3'd3, 16'h0004, "R10 trs preset by strap 01");
    @(negedge clk_i); #1 push(2, 16'h0001, "R10 trs pin");

    // non-hold mode
    field(15'h0001);
    rd(3'd0, 16'h0001, "R2 flag captured");
    chk_irq(1'b1, "R6 irq on sensitive flag");
    rd(3'd4, 16'h0001, "R9 one count per field");
    rd(3'd0, 16'h0001, "R2 read does not clear");
    rd(3'd4, 16'h0001, "R8 no auto-clear when off");
    field(15'h0000);
    rd(3'd0, 16'h0000, "R2 flags follow field");
    chk_irq(1'b0, "R6 irq drops");

    // masking
    wr(3'd1, 16'h0020);
    field(15'h0020);
    rd(3'd0, 16'h0000, "R3 masked flag");
    chk_irq(1'b0, "R3 masked irq");
    rd(3'd4, 16'h0001, "R3 masked no count");
    wr(3'd1, 16'h0000);

    // sensitivity
    wr(3'd2, 16'h1FFE);
    field(15'h0001);
    rd(3'd0, 16'h0001, "R5 insensitive flag visible");
    chk_irq(1'b0, "R5 insensitive no irq");
    rd(3'd4, 16'h0001, "R5 insensitive no count");
    wr(3'd2, 16'h0FFF);
    field(15'h4000);
    chk_irq(1'b0, "R5 shared UES off full field");
    field(15'h0200);
    chk_irq(1'b0, "R5 shared UES off active picture");
    rd(3'd4, 16'h0001, "R5 UES no count");
    wr(3'd2, 16'h1FFF);
    chk_irq(1'b1, "R6 irq follows sensitivity change");
    field(15'h0400);
    rd(3'd4, 16'h0002, "R9 count advances");
    field(15'h0000);

    // hold mode
    wr(3'd1, 16'h8000);
    field(15'h0008);
    field(15'h0000);
    rd(3'd0, 16'h0008, "R4 flag held");
    chk_irq(1'b0, "R4 irq cleared by read");
    rd(3'd0, 16'h0000, "R4 cleared after read");
    rd(3'd0, 16'h0000, "R11 read with field returns old", 1'b1, 15'h0002);
    rd(3'd0, 16'h0002, "R11 new event survives read");
    rd(3'd4, 16'h0004, "R9 count after hold fields");
    wr(3'd1, 16'h0000);

    // counter clear command
    wr(3'd3, 16'h0005);
    rd(3'd4, 16'h0000, "R7 counter held at zero");
    field(15'h0001);
    rd(3'd4, 16'h0000, "R7 no counting while held");
    wr(3'd3, 16'h0004);

    // saturation
    for (int i = 0; i < 17; i++) field(15'h0001);
    rd(3'd4, 16'h000F, "R9 saturates");

    // auto-clear
    wr(3'd3, 16'h0006);
    rd(3'd4, 16'h000F, "R8 read returns count");
    rd(3'd4, 16'h0000, "R8 cleared after read");
    rd(3'd4, 16'h0000, "R11 auto-clear read with field", 1'b1, 15'h0001);
    rd(3'd4, 16'h0001, "R11 field kept after auto-clear");
    rd(3'd4, 16'h0000, "R8 cleared again");

    idle();
    repeat (2) @(negedge clk_i);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule